// File: doc/BRIEF.md
# Dual-Processor SRAM Bank Ownership Arbiter

This block decides which of two processors, a base processor and a secondary processor, owns each of two shared SRAM banks (bank 2 and bank 3). Each processor has its own register write port. Through it, software raises requests, gives ownership back and acknowledges interrupts. The block holds the configuration, request, ownership and interrupt-cause state, and it presents that state on output ports.

There are two sharing modes. In spinlock mode, each bank is arbitrated separately and a processor asks for a bank on its own behalf. In handshake mode, the bank 2 ownership register governs both banks, and a processor's request bit is raised by the peer processor. When a bank is granted, the winner's ownership bit is set, its request is consumed, and a cause bit is logged that drives that processor's interrupt line.

Top module: `sram_bank_arb`

## Requirements
- R1: After reset, every request, ownership and log bit is 0, `sec_rst_o` is 0, the priority is base-first and the mode is spinlock.
- R2: Only the base port can write reset control (0x00), priority (0x04, bit0: 0 = base wins, 1 = secondary wins) and mode (0x34, bit0: 0 = spinlock, 1 = handshake). Secondary-port writes to these offsets change nothing.
- R3: From the edge that writes a nonzero value to 0x00, `sec_rst_o` is 1. It stays 1 until the edge that writes zero there.
- R4: Request registers are at 0x0C (base, bank 2), 0x10 (secondary, bank 2), 0x18 (base, bank 3) and 0x1C (secondary, bank 3). In spinlock mode, only the owning processor sets its request, by writing bit0 = 1. Software can never clear a request bit, and writes from the other port are ignored. Output bit index is the bank (0 = bank 2, 1 = bank 3).
- R5: A bank with both ownership bits clear and a pending request is granted on the next edge. On that edge, the winner's ownership bit is set (bit0 = base, bit1 = secondary) and its request bit is cleared. Both ownership bits are never set at once.
- R6: When both processors request a free bank, the priority bit picks the winner. The loser stays pending and is granted after the winner releases the bank.
- R7: Ownership registers are at 0x08 (bank 2) and 0x14 (bank 3). They are write-1-to-clear. Only the base port clears bit0, and only the secondary port clears bit1.
- R8: In handshake mode, the base request bits are set by secondary-port writes and the secondary request bits by base-port writes. Only bank 2 is arbitrated, and its ownership covers both banks. Writes to the bank 3 request offsets are ignored, and bank 3 is never granted.
- R9: The cause logs are at 0x28 (base) and 0x2C (secondary). Bit0 is set by a bank 2 grant and bit1 by a bank 3 grant to that processor. Only the owning port clears its log, write-1-to-clear. Each interrupt output is the OR of its log bits.
- R10: A log bit set by a grant and cleared by software on the same edge ends up set.
- R11: A pending request on a bank whose ownership is released by software is granted one edge after the release edge, not on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_we_i | input | 1 | Base processor write strobe |
| base_addr_i | input | AW | Base processor register offset |
| base_wdata_i | input | DW | Base processor write data |
| sec_we_i | input | 1 | Secondary processor write strobe |
| sec_addr_i | input | AW | Secondary processor register offset |
| sec_wdata_i | input | DW | Secondary processor write data |
| sec_rst_o | output | 1 | Holds the secondary processor in reset |
| prio_sec_o | output | 1 | Priority setting, 1 = secondary wins |
| hs_mode_o | output | 1 | Mode, 1 = handshake |
| base_req_o | output | 2 | Base request bits, index = bank |
| sec_req_o | output | 2 | Secondary request bits, index = bank |
| own_bk2_o | output | 2 | Bank 2 ownership {secondary, base} |
| own_bk3_o | output | 2 | Bank 3 ownership {secondary, base} |
| base_log_o | output | 2 | Base interrupt cause log |
| sec_log_o | output | 2 | Secondary interrupt cause log |
| base_irq_o | output | 1 | Base interrupt |
| sec_irq_o | output | 1 | Secondary interrupt |

## Verification
A grant can land on the same edge as a software clear of the winner's cause log. The bench provokes this by writing a base request and then writing the base log clear on the very next cycle. It then expects the bank 2 cause bit to survive. A second collision is an ownership release while a request is pending. The bench checks that ownership reads zero right after the release edge and shows the peer as owner one edge later. A behavioural model updated on every edge judges all outputs in every cycle alongside these directed checks.

// File: rtl/sba_pkg.sv
package sba_pkg;
  localparam int unsigned NB      = 2;
  localparam int unsigned A_RST   = 'h00;
  localparam int unsigned A_PRIO  = 'h04;
  localparam int unsigned A_OWN2  = 'h08;
  localparam int unsigned A_BREQ2 = 'h0C;
  localparam int unsigned A_SREQ2 = 'h10;
  localparam int unsigned A_OWN3  = 'h14;
  localparam int unsigned A_BREQ3 = 'h18;
  localparam int unsigned A_SREQ3 = 'h1C;
  localparam int unsigned A_BLOG  = 'h28;
  localparam int unsigned A_SLOG  = 'h2C;
  localparam int unsigned A_MODE  = 'h34;

  typedef enum logic {
    P_BASE = 1'b0,
    P_SEC  = 1'b1
  } proc_e;
endpackage

// File: rtl/sba_cfg.sv
module sba_cfg
  import sba_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          sec_rst_o,
  output logic          prio_sec_o,
  output logic          hs_mode_o
);
  logic hit_rst, hit_prio, hit_mode;
  assign hit_rst  = we_i && (addr_i == AW'(A_RST));
  assign hit_prio = we_i && (addr_i == AW'(A_PRIO));
  assign hit_mode = we_i && (addr_i == AW'(A_MODE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_rst_o  <= 1'b0;
      prio_sec_o <= 1'b0;
      hs_mode_o  <= 1'b0;
    end else begin
      if (hit_rst)  sec_rst_o  <= |wdata_i;
      if (hit_prio) prio_sec_o <= wdata_i[0];
      if (hit_mode) hs_mode_o  <= wdata_i[0];
    end
  end

  assert_rst_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_rst_o && !hit_rst) |=> sec_rst_o);
  assert_prio_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_prio |=> (prio_sec_o == $past(wdata_i[0])));
endmodule

// File: rtl/sba_bank.sv
module sba_bank (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] set_req_i,  // [0] base, [1] secondary
  input  logic [1:0] clr_own_i,
  input  logic       arb_en_i,
  input  logic       prio_sec_i,
  output logic [1:0] req_o,
  output logic [1:0] own_o,
  output logic [1:0] grant_o
);
  logic [1:0] req_q, own_q, grant;

  always_comb begin
    grant = 2'b00;
    if (arb_en_i && own_q == 2'b00) begin
      if (req_q == 2'b11) grant = prio_sec_i ? 2'b10 : 2'b01;
      else                grant = req_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 2'b00;
      own_q <= 2'b00;
    end else begin
      req_q <= (req_q | set_req_i) & ~grant;  // grant consumes a same-edge set
      own_q <= (own_q & ~clr_own_i) | grant;
    end
  end

  assign req_o   = req_q;
  assign own_o   = own_q;
  assign grant_o = grant;

  assert_own_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_q != 2'b11);
  assert_own_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(own_q[0]) |-> $past(req_q[0]));
  assert_prio_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_en_i && own_q == 2'b00 && req_q == 2'b11)
      |=> (own_q == {$past(prio_sec_i), !$past(prio_sec_i)}));
  assert_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arb_en_i && own_q == 2'b00) |=> (own_q == 2'b00));
endmodule

// File: rtl/sram_bank_arb.sv
module sram_bank_arb
  import sba_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          base_we_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [DW-1:0] base_wdata_i,
  input  logic          sec_we_i,
  input  logic [AW-1:0] sec_addr_i,
  input  logic [DW-1:0] sec_wdata_i,
  output logic          sec_rst_o,
  output logic          prio_sec_o,
  output logic          hs_mode_o,
  output logic [1:0]    base_req_o,
  output logic [1:0]    sec_req_o,
  output logic [1:0]    own_bk2_o,
  output logic [1:0]    own_bk3_o,
  output logic [1:0]    base_log_o,
  output logic [1:0]    sec_log_o,
  output logic          base_irq_o,
  output logic          sec_irq_o
);
  logic hs;
  logic [1:0] own_w [NB];
  logic [1:0] req_w [NB];
  logic [1:0] gnt_w [NB];
  logic [NB-1:0] gnt_base, gnt_sec;
  logic [1:0] base_log_q, sec_log_q;
  logic unused_sec_bits;

  assign unused_sec_bits = ^sec_wdata_i[DW-1:2];

  sba_cfg #(.AW(AW), .DW(DW)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (base_we_i),
    .addr_i     (base_addr_i),
    .wdata_i    (base_wdata_i),
    .sec_rst_o  (sec_rst_o),
    .prio_sec_o (prio_sec_o),
    .hs_mode_o  (hs)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam int unsigned AOWN  = (b == 0) ? A_OWN2  : A_OWN3;
    localparam int unsigned ABREQ = (b == 0) ? A_BREQ2 : A_BREQ3;
    localparam int unsigned ASREQ = (b == 0) ? A_SREQ2 : A_SREQ3;
    localparam bit          SHARED = (b == 0);
    logic b_breq, b_sreq, s_breq, s_sreq, en;
    logic [1:0] set_req, clr_own;

    assign b_breq = base_we_i && base_addr_i == AW'(ABREQ) && base_wdata_i[0];
    assign b_sreq = base_we_i && base_addr_i == AW'(ASREQ) && base_wdata_i[0];
    assign s_breq = sec_we_i  && sec_addr_i  == AW'(ABREQ) && sec_wdata_i[0];
    assign s_sreq = sec_we_i  && sec_addr_i  == AW'(ASREQ) && sec_wdata_i[0];
    assign en     = SHARED || !hs;
    // handshake: the peer raises each request
    assign set_req[P_BASE] = en && (hs ? s_breq : b_breq);
    assign set_req[P_SEC]  = en && (hs ? b_sreq : s_sreq);
    assign clr_own[P_BASE] = base_we_i && base_addr_i == AW'(AOWN) && base_wdata_i[0];
    assign clr_own[P_SEC]  = sec_we_i  && sec_addr_i  == AW'(AOWN) && sec_wdata_i[1];

    sba_bank u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_req_i  (set_req),
      .clr_own_i  (clr_own),
      .arb_en_i   (en),
      .prio_sec_i (prio_sec_o),
      .req_o      (req_w[b]),
      .own_o      (own_w[b]),
      .grant_o    (gnt_w[b])
    );

    assign gnt_base[b]   = gnt_w[b][P_BASE];
    assign gnt_sec[b]    = gnt_w[b][P_SEC];
    assign base_req_o[b] = req_w[b][P_BASE];
    assign sec_req_o[b]  = req_w[b][P_SEC];

    assert_log_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(base_log_q[b]) |-> own_w[b][P_BASE]);
  end

  logic [1:0] base_clr, sec_clr;
  assign base_clr = (base_we_i && base_addr_i == AW'(A_BLOG)) ? base_wdata_i[1:0] : 2'b00;
  assign sec_clr  = (sec_we_i  && sec_addr_i  == AW'(A_SLOG)) ? sec_wdata_i[1:0]  : 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_log_q <= 2'b00;
      sec_log_q  <= 2'b00;
    end else begin
      base_log_q <= (base_log_q & ~base_clr) | gnt_base;  // set beats clear
      sec_log_q  <= (sec_log_q  & ~sec_clr)  | gnt_sec;
    end
  end

  assign hs_mode_o  = hs;
  assign own_bk2_o  = own_w[0];
  assign own_bk3_o  = own_w[1];
  assign base_log_o = base_log_q;
  assign sec_log_o  = sec_log_q;
  assign base_irq_o = |base_log_q;
  assign sec_irq_o  = |sec_log_q;

  assert_log_keep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(base_we_i && base_addr_i == AW'(A_BLOG))
      |=> ((base_log_q & $past(base_log_q)) == $past(base_log_q)));
  assert_log_keep_sec_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sec_we_i && sec_addr_i == AW'(A_SLOG))
      |=> ((sec_log_q & $past(sec_log_q)) == $past(sec_log_q)));
  assert_log_win_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_base != 2'b00) |=> ((base_log_q & $past(gnt_base)) == $past(gnt_base)));
endmodule

// File: tb/sim_sram_bank_arb.sv
`timescale 1ns/1ps
module sim_sram_bank_arb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bwe = 1'b0, swe = 1'b0;
  logic [7:0]  ba = '0, sa = '0;
  logic [31:0] bd = '0, sd = '0;
  logic sec_rst, prio, hs, birq, sirq;
  logic [1:0] breq, sreq, own2, own3, blog, slog;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sram_bank_arb u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .base_we_i(bwe), .base_addr_i(ba), .base_wdata_i(bd),
    .sec_we_i(swe), .sec_addr_i(sa), .sec_wdata_i(sd),
    .sec_rst_o(sec_rst), .prio_sec_o(prio), .hs_mode_o(hs),
    .base_req_o(breq), .sec_req_o(sreq),
    .own_bk2_o(own2), .own_bk3_o(own3),
    .base_log_o(blog), .sec_log_o(slog),
    .base_irq_o(birq), .sec_irq_o(sirq)
  );

  // reference model: index [bank][who], log [who][bank]; who 0 = base, 1 = secondary
  bit m_rst, m_prio, m_hs;
  bit m_req [2][2];
  bit m_own [2][2];
  bit m_log [2][2];

  function automatic int req_off(int b, int w);
    return (b == 0) ? (w == 0 ? 12 : 16) : (w == 0 ? 24 : 28);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rst = 0; m_prio = 0; m_hs = 0;
      for (int b = 0; b < 2; b++)
        for (int w = 0; w < 2; w++) begin
          m_req[b][w] = 0; m_own[b][w] = 0; m_log[w][b] = 0;
        end
    end else begin
      int win [2];
      bit nreq [2][2];
      bit nown [2][2];
      bit nlog [2][2];
      bit nrst, nprio, nhs;
      nrst = m_rst; nprio = m_prio; nhs = m_hs;
      nreq = m_req; nown = m_own; nlog = m_log;
      for (int b = 0; b < 2; b++) begin
        win[b] = -1;
        if ((b == 0 || !m_hs) && !m_own[b][0] && !m_own[b][1]) begin
          if (m_req[b][0] && m_req[b][1]) win[b] = int'(m_prio);
          else if (m_req[b][0]) win[b] = 0;
          else if (m_req[b][1]) win[b] = 1;
        end
      end
      if (bwe) begin
        if (ba == 8'h00) nrst = (bd != 0);
        if (ba == 8'h04) nprio = bd[0];
        if (ba == 8'h34) nhs = bd[0];
        if (ba == 8'h08 && bd[0]) nown[0][0] = 0;
        if (ba == 8'h14 && bd[0]) nown[1][0] = 0;
        if (ba == 8'h28) begin
          if (bd[0]) nlog[0][0] = 0;
          if (bd[1]) nlog[0][1] = 0;
        end
      end
      if (swe) begin
        if (sa == 8'h08 && sd[1]) nown[0][1] = 0;
        if (sa == 8'h14 && sd[1]) nown[1][1] = 0;
        if (sa == 8'h2C) begin
          if (sd[0]) nlog[1][0] = 0;
          if (sd[1]) nlog[1][1] = 0;
        end
      end
      for (int b = 0; b < 2; b++)
        for (int w = 0; w < 2; w++) begin
          int writer;
          bit hit;
          writer = m_hs ? 1 - w : w;
          if (writer == 0) hit = bwe && ba == 8'(req_off(b, w)) && bd[0];
          else             hit = swe && sa == 8'(req_off(b, w)) && sd[0];
          if (hit && (b == 0 || !m_hs)) nreq[b][w] = 1;
        end
      for (int b = 0; b < 2; b++)
        if (win[b] >= 0) begin
          nreq[b][win[b]] = 0;
          nown[b][win[b]] = 1;
          nlog[win[b]][b] = 1;
        end
      m_rst = nrst; m_prio = nprio; m_hs = nhs;
      m_req = nreq; m_own = nown; m_log = nlog;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R3 sec_rst model", 8'(sec_rst), 8'(m_rst));
    chk("R2 prio model", 8'(prio), 8'(m_prio));
    chk("R8 mode model", 8'(hs), 8'(m_hs));
    chk("R4 base_req model", 8'(breq), 8'({m_req[1][0], m_req[0][0]}));
    chk("R4 sec_req model", 8'(sreq), 8'({m_req[1][1], m_req[0][1]}));
    chk("R5 own bank2 model", 8'(own2), 8'({m_own[0][1], m_own[0][0]}));
    chk("R5 own bank3 model", 8'(own3), 8'({m_own[1][1], m_own[1][0]}));
    chk("R9 base_log model", 8'(blog), 8'({m_log[0][1], m_log[0][0]}));
    chk("R9 sec_log model", 8'(slog), 8'({m_log[1][1], m_log[1][0]}));
    chk("R9 irq model", 8'({sirq, birq}),
        8'({m_log[1][1] | m_log[1][0], m_log[0][1] | m_log[0][0]}));
  end

  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    bwe = 1; ba = a; bd = d;
    @(negedge clk);
    bwe = 0; ba = '0; bd = '0;
  endtask

  task automatic swr(input logic [7:0] a, input logic [31:0] d);
    swe = 1; sa = a; sd = d;
    @(negedge clk);
    swe = 0; sa = '0; sd = '0;
  endtask

  task automatic both(input logic [7:0] a1, input logic [31:0] d1,
                      input logic [7:0] a2, input logic [31:0] d2);
    bwe = 1; ba = a1; bd = d1; swe = 1; sa = a2; sd = d2;
    @(negedge clk);
    bwe = 0; ba = '0; bd = '0; swe = 0; sa = '0; sd = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(1);
    // R1 reset state
    chk("R1 own/log", {own3, own2, slog, blog}, 8'h00);
    chk("R1 cfg", {5'b0, sec_rst, prio, hs}, 8'h00);
    chk("R1 req", {4'b0, sreq, breq}, 8'h00);
    // R2 secondary cannot write config
    swr(8'h04, 1); swr(8'h34, 1); swr(8'h00, 1);
    chk("R2 sec config write ignored", {5'b0, sec_rst, prio, hs}, 8'h00);
    // R3 reset control
    bwr(8'h00, 5);
    chk("R3 reset held", 8'(sec_rst), 8'h01);
    idle(2);
    chk("R3 reset still held", 8'(sec_rst), 8'h01);
    bwr(8'h00, 0);
    chk("R3 reset released", 8'(sec_rst), 8'h00);
    // R4 only owner sets its request in spinlock
    swr(8'h0C, 1); idle(1);
    chk("R4 foreign request write ignored", {4'b0, breq, own2}, 8'h00);
    bwr(8'h0C, 1);
    chk("R4 base request set", 8'(breq), 8'h01);
    idle(1);
    chk("R5 bank2 granted to base", 8'(own2), 8'h01);
    chk("R5 request consumed", 8'(breq), 8'h00);
    chk("R9 base log bank2", {6'b0, birq, blog[0]}, 8'h03);
    // R7 / R11
    swr(8'h10, 1); idle(1);
    chk("R5 secondary pending while owned", {4'b0, sreq, own2}, 8'h05);
    swr(8'h08, 1); idle(1);
    chk("R7 secondary cannot clear base bit", 8'(own2), 8'h01);
    bwr(8'h08, 1);
    chk("R11 no grant on release edge", 8'(own2), 8'h00);
    idle(1);
    chk("R11 grant after release", 8'(own2), 8'h02);
    chk("R9 secondary log and irq", {6'b0, sirq, slog[0]}, 8'h03);
    swr(8'h28, 3);
    chk("R9 foreign log clear ignored", 8'(blog), 8'h01);
    // R6 priority
    swr(8'h08, 2);
    bwr(8'h04, 1);
    both(8'h18, 1, 8'h1C, 1);
    idle(1);
    chk("R6 secondary wins bank3", 8'(own3), 8'h02);
    chk("R6 base still pending", 8'(breq), 8'h02);
    swr(8'h14, 2); idle(1);
    chk("R6 loser served after release", 8'(own3), 8'h01);
    // R10 set beats clear
    bwr(8'h28, 3);
    chk("R9 base log cleared", 8'(blog), 8'h00);
    bwr(8'h0C, 1);
    bwr(8'h28, 1);
    chk("R10 grant set beats clear", 8'(blog), 8'h01);
    chk("R10 bank2 owned by base", 8'(own2), 8'h01);
    // R8 handshake
    bwr(8'h08, 1); bwr(8'h14, 1);
    bwr(8'h34, 1);
    chk("R8 handshake mode", 8'(hs), 8'h01);
    bwr(8'h10, 1); idle(1);
    chk("R8 base raised secondary grant", 8'(own2), 8'h02);
    bwr(8'h0C, 1); idle(1);
    chk("R8 own request write ignored", 8'(breq), 8'h00);
    swr(8'h0C, 1);
    chk("R8 peer raised base request", 8'(breq), 8'h01);
    swr(8'h18, 1); idle(1);
    chk("R8 bank3 request ignored", {4'b0, breq, own3}, 8'h04);
    swr(8'h08, 2); idle(1);
    chk("R8 base granted after release", 8'(own2), 8'h01);
    idle(3);
    finish_run();
  end
endmodule